// File: doc/BRIEF.md
# GPIO Port with Interrupt Detection

A 32-pin general-purpose I/O port behind a simple single-cycle register bus. Software sets the driven level of each pin through an output data register and picks per pin whether it drives through a direction register. It samples the pads through a read-only pad status register. Every pad input passes through a two-flop synchronizer. After that, each pin has its own event detector, which can fire on a low level, a high level, a rising edge, a falling edge, or both edges.

Detected events are latched in a pending register, and software clears them by writing ones. A mask register enables each pin. Two request lines leave the block. One covers pins 0 to 15 and the other covers pins 16 to 31, so the two halves can be served by separate handlers. Writes take effect on the clock edge on which `reg_we` is high. Reads are combinational from `reg_addr`. Register offsets are byte offsets equal to 4 × `reg_addr`.

Top module: `gpio_irq_port`

## Requirements
- R1: While reset is held and directly after it, every register reads zero, `pad_out` and `pad_oe` are zero, and both request lines are low.
- R2: The output data register (index 0, offset 0x00) drives `pad_out`, and the direction register (index 1, offset 0x04, 1 = output) drives `pad_oe`. Both change on the clock edge of their write, read back as written, and change at no other time.
- R3: The pad status register (index 2, offset 0x08) returns each pin's input after the two-flop synchronizer. A pad change is readable after the second rising edge that follows it, and is not readable after the first.
- R4: Pins 0–15 take their trigger mode from configuration word A (index 3, offset 0x0C). Pins 16–31 take it from word B (index 4, offset 0x10). Pin i uses the 2-bit field at bits 2·(i mod 16)+1 : 2·(i mod 16), encoded 00 low level, 01 high level, 10 rising edge, 11 falling edge.
- R5: Edge modes compare the current synchronized value with the previous one, and they set the pin's pending bit on the third rising edge after the pad change. A transition in the other direction sets nothing.
- R6: When bit i of the both-edges register (index 7, offset 0x1C) is 1, pin i sets its pending bit on every transition, whatever its 2-bit field holds.
- R7: Writing the pending register (index 6, offset 0x18) clears each bit written as 1 and leaves each bit written as 0 unchanged. Without such a write, a pending bit is never lost.
- R8: A level-mode pending bit whose level still holds reads 0 right after it is cleared and reads 1 again one cycle later. In level mode a clear wins over a coincident detection; in edge mode a coincident edge wins.
- R9: `irq_lo` is the OR over pins 0–15 of pending AND mask (index 5, offset 0x14, 1 = enabled), and `irq_hi` is the same over pins 16–31. With all mask bits 0, both lines stay low.
- R10: Writes to the pad status register have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Write strobe for the register bus |
| reg_addr | input | 3 | Register index (byte offset / 4) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| pad_in | input | 32 | Pad input levels |
| pad_out | output | 32 | Driven pad levels |
| pad_oe | output | 32 | Per-pin output enable |
| irq_lo | output | 1 | Request line for pins 0–15 |
| irq_hi | output | 1 | Request line for pins 16–31 |

## Verification
A register write is visible on `pad_out`, `pad_oe` and read-back at the falling edge right after the write edge. A pad change appears in pad status two rising edges later. It reaches the pending bits and request lines three rising edges later. The directed checks therefore sample at exactly those falling edges, and each latency check also samples one edge early to confirm the value has not yet arrived. For random traffic, a cycle model in the bench advances on each rising edge and is compared with the outputs at every falling edge.

// File: rtl/gpio_irq_port.sv
module gpio_irq_port #(
  parameter int N_PINS = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [N_PINS-1:0] reg_wdata,
  output logic [N_PINS-1:0] reg_rdata,
  input  logic [N_PINS-1:0] pad_in,
  output logic [N_PINS-1:0] pad_out,
  output logic [N_PINS-1:0] pad_oe,
  output logic              irq_lo,
  output logic              irq_hi
);
  localparam int HALF = N_PINS / 2;
  localparam logic [ADDR_W-1:0] A_DATA = 0, A_DIR = 1, A_PAD = 2, A_CFGA = 3,
                                A_CFGB = 4, A_MASK = 5, A_PEND = 6, A_BOTH = 7;

  logic [N_PINS-1:0] data_q, dir_q, cfga_q, cfgb_q, mask_q, pend_q, both_q;
  logic [N_PINS-1:0] sync1_q, sync2_q, prev_q;
  logic [N_PINS-1:0] ev, edge_md, clr, pend_nx;

  assign clr = (reg_we && reg_addr == A_PEND) ? reg_wdata : '0;

  for (genvar g = 0; g < N_PINS; g++) begin : g_pin
    localparam int F = 2 * (g % HALF);
    logic [1:0] md;
    logic rise, fall;
    if (g < HALF) begin : g_a
      assign md = cfga_q[F+1:F];
    end else begin : g_b
      assign md = cfgb_q[F+1:F];
    end
    assign rise = sync2_q[g] & ~prev_q[g];
    assign fall = ~sync2_q[g] & prev_q[g];
    always_comb begin
      if (both_q[g]) ev[g] = rise | fall;
      else begin
        case (md)
          2'b00:   ev[g] = ~sync2_q[g];
          2'b01:   ev[g] = sync2_q[g];
          2'b10:   ev[g] = rise;
          default: ev[g] = fall;
        endcase
      end
    end
    assign edge_md[g] = both_q[g] | md[1];
  end

  assign pend_nx = (pend_q & ~clr) | (ev & (edge_md | ~clr));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0; dir_q <= '0; cfga_q <= '0; cfgb_q <= '0;
      mask_q <= '0; pend_q <= '0; both_q <= '0;
      sync1_q <= '0; sync2_q <= '0; prev_q <= '0;
    end else begin
      sync1_q <= pad_in;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
      pend_q  <= pend_nx;
      if (reg_we) begin
        case (reg_addr)
          A_DATA: data_q <= reg_wdata;
          A_DIR:  dir_q  <= reg_wdata;
          A_CFGA: cfga_q <= reg_wdata;
          A_CFGB: cfgb_q <= reg_wdata;
          A_MASK: mask_q <= reg_wdata;
          A_BOTH: both_q <= reg_wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (reg_addr)
      A_DATA:  reg_rdata = data_q;
      A_DIR:   reg_rdata = dir_q;
      A_PAD:   reg_rdata = sync2_q;
      A_CFGA:  reg_rdata = cfga_q;
      A_CFGB:  reg_rdata = cfgb_q;
      A_MASK:  reg_rdata = mask_q;
      A_PEND:  reg_rdata = pend_q;
      default: reg_rdata = both_q;
    endcase
  end

  assign pad_out = data_q;
  assign pad_oe  = dir_q;
  assign irq_lo  = |(pend_q[HALF-1:0] & mask_q[HALF-1:0]);
  assign irq_hi  = |(pend_q[N_PINS-1:HALF] & mask_q[N_PINS-1:HALF]);

  AST_OE_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(reg_we && reg_addr == A_DIR) |-> $stable(pad_oe)); // R2
  AST_PEND_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q & ~$past(pend_q) & ~$past(ev)) == '0); // R5
  AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(reg_we && reg_addr == A_PEND) |-> ((pend_q & $past(pend_q)) == $past(pend_q))); // R7
  AST_LEVEL_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(reg_we && reg_addr == A_PEND) |-> ((pend_q & $past(reg_wdata & ~edge_md)) == '0)); // R8
  AST_MASK_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !(irq_lo || irq_hi)); // R9
endmodule

// File: tb/gpio_irq_port_tb.sv
`timescale 1ns/1ps
module gpio_irq_port_tb;
  logic clk = 0, rst_n = 0, we = 0;
  logic [2:0] addr = 0;
  logic [31:0] wdata = 0, rdata, pad_in = 0, pad_out, pad_oe;
  logic irq_lo, irq_hi;
  int checks = 0, errors = 0;
  bit model_on = 0;

  always #2.5 clk = ~clk;

  gpio_irq_port u_dut (.clk(clk), .rst_n(rst_n), .reg_we(we), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rdata), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .irq_lo(irq_lo), .irq_hi(irq_hi));

  logic [31:0] m_reg [8];
  logic [31:0] m_s1, m_s2, m_s3;

  function automatic logic f_ev(logic [1:0] md, logic b, logic cur, logic prv);
    if (b) return cur ^ prv;
    case (md)
      2'b00: return !cur;
      2'b01: return cur;
      2'b10: return cur & !prv;
      default: return !cur & prv;
    endcase
  endfunction

  function automatic logic [31:0] f_read(int idx);
    return (idx == 2) ? m_s2 : m_reg[idx];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) m_reg[i] <= '0;
      m_s1 <= '0; m_s2 <= '0; m_s3 <= '0;
    end else begin
      logic [31:0] nx, cl;
      cl = (we && addr == 6) ? wdata : '0;
      for (int i = 0; i < 32; i++) begin
        logic [1:0] md;
        logic e, em;
        md = (i < 16) ? m_reg[3][2*i +: 2] : m_reg[4][2*(i-16) +: 2];
        e  = f_ev(md, m_reg[7][i], m_s2[i], m_s3[i]);
        em = m_reg[7][i] | md[1];
        nx[i] = (m_reg[6][i] & !cl[i]) | (e & (em | !cl[i]));
      end
      m_reg[6] <= nx;
      if (we && addr != 6 && addr != 2) m_reg[addr] <= wdata;
      m_s1 <= pad_in; m_s2 <= m_s1; m_s3 <= m_s2;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (model_on) begin
    chk("R9 irq_lo", {31'd0, irq_lo}, {31'd0, |(m_reg[6][15:0] & m_reg[5][15:0])});
    chk("R9 irq_hi", {31'd0, irq_hi}, {31'd0, |(m_reg[6][31:16] & m_reg[5][31:16])});
    chk("R2 pad_out", pad_out, m_reg[0]);
    chk("R2 pad_oe", pad_oe, m_reg[1]);
  end

  task automatic wr(logic [2:0] a, logic [31:0] d);
    addr = a; wdata = d; we = 1;
    @(negedge clk);
    we = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic rdchk(string req, logic [2:0] a, logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd4242));
    wait_n(2);
    for (int i = 0; i < 8; i++) rdchk("R1 reset reg", i[2:0], 32'd0);
    chk("R1 reset outputs", {pad_out | pad_oe, 30'd0, irq_lo, irq_hi}, '0);
    @(negedge clk); rst_n = 1; model_on = 1;
    @(negedge clk);
    chk("R1 irq after reset", {30'd0, irq_lo, irq_hi}, 0);

    wr(0, 32'hA5A5_0F0F); wr(1, 32'hFFFF_0000);
    chk("R2 pad_out", pad_out, 32'hA5A5_0F0F);
    chk("R2 pad_oe", pad_oe, 32'hFFFF_0000);
    rdchk("R2 dir readback", 1, 32'hFFFF_0000);

    wr(2, 32'hFFFF_FFFF);
    rdchk("R10 pad status write ignored", 2, 32'd0);

    pad_in = 32'h1234_5678;
    @(negedge clk); rdchk("R3 pad status early", 2, 32'd0);
    @(negedge clk); rdchk("R3 pad status", 2, 32'h1234_5678);

    pad_in = 0;
    wr(3, 32'hAAAA_AAAA); wr(4, 32'hAAAA_AAAA);
    wait_n(3);
    wr(6, 32'hFFFF_FFFF);
    rdchk("R7 clear all", 6, 32'd0);

    wr(5, 32'hFFFF_FFFF);
    pad_in = 32'h8;
    wait_n(2); chk("R5 rise early", {31'd0, irq_lo}, 0);
    @(negedge clk); chk("R5 rise irq_lo", {30'd0, irq_lo, irq_hi}, 32'd2);
    rdchk("R4 rise pin3 pending", 6, 32'h8);
    wr(6, 32'h0); rdchk("R7 zero write keeps", 6, 32'h8);
    wr(6, 32'h8); rdchk("R7 one write clears", 6, 32'h0);
    chk("R9 irq_lo cleared", {31'd0, irq_lo}, 0);

    wr(4, 32'hAAAA_ABAA);
    pad_in = 32'h8 | (32'h1 << 20);
    wait_n(3); rdchk("R5 falling ignores rise", 6, 32'h0);
    pad_in = 32'h8;
    wait_n(3);
    chk("R4 pin20 on irq_hi", {30'd0, irq_lo, irq_hi}, 32'd1);
    rdchk("R4 pin20 falling", 6, 32'h1 << 20);
    wr(6, 32'h1 << 20);

    wr(7, 32'h8);
    pad_in = 32'h0;
    wait_n(3); rdchk("R6 both-edges fall", 6, 32'h8);
    wr(6, 32'h8);
    pad_in = 32'h8;
    wait_n(3); rdchk("R6 both-edges rise", 6, 32'h8);
    wr(6, 32'h8); wr(7, 32'h0);

    wr(3, 32'hAAAA_A6AA);
    pad_in = 32'h28;
    wait_n(3); rdchk("R8 high level sets", 6, 32'h20);
    wr(6, 32'h20); rdchk("R8 reads zero after clear", 6, 32'h0);
    @(negedge clk); rdchk("R8 set again", 6, 32'h20);
    wr(5, 32'h0); chk("R9 masked off", {31'd0, irq_lo}, 0);
    wr(5, 32'h20); chk("R9 unmasked", {31'd0, irq_lo}, 1);

    for (int c = 0; c < 4000; c++) begin
      int op;
      pad_in = pad_in ^ ($urandom & $urandom & $urandom);
      op = $urandom % 4;
      if (op == 0) wr(3'($urandom % 8), $urandom);
      else begin
        int idx;
        idx = $urandom % 8;
        rd(idx[2:0], v);
        chk("R4 random readback", v, f_read(idx));
        @(negedge clk);
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule